// File: doc/BRIEF.md
# Two-Cycle Ramp Frequency Estimator

This block gives a digitally controlled oscillator a starting control word within two reference periods, so that the slower tracking loops start close to the target frequency. After `start` it holds the control word at zero, the shortest oscillator period. It then waits for a reference edge. From that edge until the next reference edge, it adds a fixed increment to the word at every edge of the divided oscillator output. At the second reference edge the word freezes.

During the ramped period the first converter strobe gives the minimum divided-output period. The first strobe after the freeze gives the period produced by the final ramped word. The oscillator is treated as linear, so the period grows in proportion to the word. From this the block derives a word for the target period: the ramped word times (target − minimum) divided by (measured − minimum). A bit-serial divider computes it, and the result saturates at full scale. If the measured period is not longer than the minimum, there is no usable slope, and the block reports an error in place of a result.

All edge inputs are single-cycle pulses that are already synchronised to `clk`. The converter and the oscillator lie outside the block.

Top module: `ramp_freq_estimator`

## Requirements
- R1: After reset `ctrl_word`, `init_word`, `meas_period`, `done` and `err` are 0. `start` is accepted only when the block is idle or finished. Accepting it clears `ctrl_word`, `init_word`, `err` and `done`. A `start` pulse at any other time has no effect.
- R2: After `start`, `fb_edge` pulses seen before the first `ref_edge` leave `ctrl_word` at 0. This includes a pulse that coincides with the first `ref_edge`.
- R3: Between the first and second `ref_edge`, each `fb_edge` pulse adds the parameter P (default 5) to `ctrl_word`, visible one clock later. The sum saturates at 2^CW−1 (default 4095).
- R4: A `fb_edge` that coincides with the second `ref_edge` adds nothing. From then until the next accepted `start`, `ctrl_word` does not change.
- R5: The minimum period is the `tdc_code` of the first `tdc_valid` strobe after the first `ref_edge` and before the second. Later strobes in that window are ignored. `meas_period` takes the code of the first strobe after the second `ref_edge`.
- R6: When the measured code exceeds the minimum, `init_word` = floor(ctrl_word × max(tgt_period − min, 0) / (meas − min)), saturated to 2^CW−1.
- R7: When the measured code is less than or equal to the minimum, `err` and `done` are 1 one clock after that strobe, and `init_word` stays 0.
- R8: On the valid path, `done` rises exactly CW+TW+1 clocks after the capturing strobe (23 with the defaults). It then stays high until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a new acquisition |
| ref_edge | input | 1 | One-cycle pulse per reference rising edge |
| fb_edge | input | 1 | One-cycle pulse per divided-output rising edge |
| tdc_valid | input | 1 | Strobe qualifying `tdc_code` |
| tdc_code | input | TW | Period measured by the time-to-digital converter |
| tgt_period | input | TW | Target period in converter units |
| ctrl_word | output | CW | Oscillator control word (ramped, then held) |
| meas_period | output | TW | Period captured after the ramp |
| init_word | output | CW | Computed initial control word |
| done | output | 1 | Acquisition finished |
| err | output | 1 | Measured period not above the minimum |

## Verification
The bench sends divided-output pulses before the first reference edge and on both reference edges. A design that counts any of them ends with a word one or more P too large. It adds an extra converter strobe inside the ramped period. A design that keeps the latest strobe instead of the first one computes the wrong minimum and the wrong initial word. Long ramps and a denominator of one drive both the word and the quotient past full scale, which a design without saturation would wrap. Equal and reversed measured/minimum codes test the error path, which a careless design would send into a divide by zero. The bench times `done` exactly, so a divider with one step too many or too few is caught.

// File: rtl/rfe_pkg.sv
package rfe_pkg;
  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_WAIT_REF1 = 3'd1,
    ST_RAMP      = 3'd2,
    ST_CAPTURE   = 3'd3,
    ST_COMPUTE   = 3'd4,
    ST_DONE      = 3'd5
  } rfe_state_t;
endpackage

// File: rtl/rfe_ramp_word.sv
module rfe_ramp_word #(
  parameter int CW   = 12,
  parameter int STEP = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          step,
  output logic [CW-1:0] word
);
  localparam logic [CW:0] WMAX = {1'b0, {CW{1'b1}}};

  function automatic logic [CW-1:0] sat_inc(input logic [CW-1:0] w);
    logic [CW:0] s;
    s = {1'b0, w} + (CW+1)'(STEP);
    return (s > WMAX) ? WMAX[CW-1:0] : s[CW-1:0];
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     word <= '0;
    else if (clear) word <= '0;
    else if (step)  word <= sat_inc(word);
  end

  a_r3_saturate_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clear && word == WMAX[CW-1:0]) |=> word == WMAX[CW-1:0]);
  a_r3_step_grows: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clear && word != WMAX[CW-1:0]) |=> word > $past(word));
endmodule

// File: rtl/rfe_tdc_capture.sv
module rfe_tdc_capture #(
  parameter int TW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          min_win,
  input  logic          meas_win,
  input  logic          valid,
  input  logic [TW-1:0] code,
  output logic [TW-1:0] min_code,
  output logic [TW-1:0] meas_code
);
  logic min_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      min_code  <= '0;
      min_seen  <= 1'b0;
      meas_code <= '0;
    end else if (clear) begin
      min_code  <= '0;
      min_seen  <= 1'b0;
      meas_code <= '0;
    end else begin
      if (min_win && valid && !min_seen) begin
        min_code <= code;
        min_seen <= 1'b1;
      end
      if (meas_win && valid) meas_code <= code;
    end
  end

  a_r5_min_first_only: assert property (@(posedge clk) disable iff (!rst_n)
    (min_seen && !clear) |=> $stable(min_code));
endmodule

// File: rtl/rfe_serial_div.sv
module rfe_serial_div #(
  parameter int NW = 22,
  parameter int DW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [NW-1:0] num,
  input  logic [DW-1:0] den,
  output logic          busy,
  output logic          fin,
  output logic [NW-1:0] quo
);
  localparam int CNTW = $clog2(NW + 1);

  logic [DW:0]     rem;
  logic [DW-1:0]   den_q;
  logic [CNTW-1:0] cnt;

  function automatic logic [DW+NW:0] div_step(input logic [DW:0] r,
                                               input logic [NW-1:0] q,
                                               input logic [DW-1:0] d);
    logic [DW:0] sh;
    sh = {r[DW-1:0], q[NW-1]};
    if (sh >= {1'b0, d}) return {sh - {1'b0, d}, q[NW-2:0], 1'b1};
    else                 return {sh, q[NW-2:0], 1'b0};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem <= '0; quo <= '0; den_q <= '0; cnt <= '0; busy <= 1'b0; fin <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (load) begin
        rem   <= '0;
        quo   <= num;
        den_q <= den;
        cnt   <= CNTW'(NW);
        busy  <= 1'b1;
      end else if (busy) begin
        {rem, quo} <= div_step(rem, quo, den_q);
        cnt <= cnt - 1'b1;
        if (cnt == CNTW'(1)) begin
          busy <= 1'b0;
          fin  <= 1'b1;
        end
      end
    end
  end

  a_r8_busy_counts: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> cnt != '0);
  a_r8_fin_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> !fin);
endmodule

// File: rtl/ramp_freq_estimator.sv
module ramp_freq_estimator #(
  parameter int CW   = 12,
  parameter int TW   = 10,
  parameter int STEP = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          ref_edge,
  input  logic          fb_edge,
  input  logic          tdc_valid,
  input  logic [TW-1:0] tdc_code,
  input  logic [TW-1:0] tgt_period,
  output logic [CW-1:0] ctrl_word,
  output logic [TW-1:0] meas_period,
  output logic [CW-1:0] init_word,
  output logic          done,
  output logic          err
);
  import rfe_pkg::*;

  localparam int NB = CW + TW;
  localparam logic [NB-1:0] QMAX = NB'({CW{1'b1}});

  rfe_state_t st;
  logic          arm, ramp_step, min_win, meas_win, bad_meas, div_load;
  logic          div_busy, div_fin;
  logic [TW-1:0] min_code;
  logic [NB-1:0] div_num, div_quo;
  logic [TW-1:0] div_den;

  function automatic logic [NB-1:0] scaled_num(input logic [CW-1:0] w,
                                               input logic [TW-1:0] tgt,
                                               input logic [TW-1:0] mn);
    logic [TW-1:0] span;
    span = (tgt > mn) ? tgt - mn : '0;
    return NB'(w) * NB'(span);
  endfunction

  function automatic logic [CW-1:0] clamp_word(input logic [NB-1:0] q);
    return (q > QMAX) ? {CW{1'b1}} : q[CW-1:0];
  endfunction

  assign arm       = start && (st == ST_IDLE || st == ST_DONE);
  assign ramp_step = (st == ST_RAMP) && fb_edge && !ref_edge;
  assign min_win   = (st == ST_RAMP);
  assign meas_win  = (st == ST_CAPTURE);
  assign bad_meas  = (tdc_code <= min_code);
  assign div_load  = meas_win && tdc_valid && !bad_meas;
  assign div_num   = scaled_num(ctrl_word, tgt_period, min_code);
  assign div_den   = tdc_code - min_code;
  assign done      = (st == ST_DONE);

  rfe_ramp_word #(.CW(CW), .STEP(STEP)) i_ramp (
    .clk(clk), .rst_n(rst_n), .clear(arm), .step(ramp_step), .word(ctrl_word));

  rfe_tdc_capture #(.TW(TW)) i_cap (
    .clk(clk), .rst_n(rst_n), .clear(arm), .min_win(min_win), .meas_win(meas_win),
    .valid(tdc_valid), .code(tdc_code), .min_code(min_code), .meas_code(meas_period));

  rfe_serial_div #(.NW(NB), .DW(TW)) i_div (
    .clk(clk), .rst_n(rst_n), .load(div_load), .num(div_num), .den(div_den),
    .busy(div_busy), .fin(div_fin), .quo(div_quo));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE;
      err <= 1'b0;
      init_word <= '0;
    end else begin
      unique case (st)
        ST_IDLE:      if (arm) st <= ST_WAIT_REF1;
        ST_WAIT_REF1: if (ref_edge) st <= ST_RAMP;
        ST_RAMP:      if (ref_edge) st <= ST_CAPTURE;
        ST_CAPTURE:   if (tdc_valid) begin
                        if (bad_meas) begin
                          st  <= ST_DONE;
                          err <= 1'b1;
                        end else begin
                          st <= ST_COMPUTE;
                        end
                      end
        ST_COMPUTE:   if (div_fin) begin
                        st <= ST_DONE;
                        init_word <= clamp_word(div_quo);
                      end
        ST_DONE:      if (arm) begin
                        st <= ST_WAIT_REF1;
                        err <= 1'b0;
                        init_word <= '0;
                      end
        default:      st <= ST_IDLE;
      endcase
    end
  end

  a_r2_wait_word_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WAIT_REF1) |-> ctrl_word == '0);
  a_r4_word_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_CAPTURE || st == ST_COMPUTE || st == ST_DONE) && !arm) |=> $stable(ctrl_word));
  a_r7_err_only_done: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (done && init_word == '0));
  a_r8_compute_has_div: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_COMPUTE) |-> (div_busy || div_fin));
  a_r1_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);
endmodule

// File: tb/test_ramp_freq_estimator.sv
module test_ramp_freq_estimator;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 12, TW = 10, STEP = 5;
  localparam int NB = CW + TW;
  localparam longint WMAX = (1 << CW) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, ref_edge = 0, fb_edge = 0, tdc_valid = 0;
  logic [TW-1:0] tdc_code = '0, tgt_period = '0;
  logic [CW-1:0] ctrl_word, init_word;
  logic [TW-1:0] meas_period;
  logic done, err;
  int n_chk = 0, n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ramp_freq_estimator #(.CW(CW), .TW(TW), .STEP(STEP)) i_ramp_freq_estimator (
    .clk(clk), .rst_n(rst_n), .start(start), .ref_edge(ref_edge), .fb_edge(fb_edge),
    .tdc_valid(tdc_valid), .tdc_code(tdc_code), .tgt_period(tgt_period),
    .ctrl_word(ctrl_word), .meas_period(meas_period), .init_word(init_word),
    .done(done), .err(err));

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cyc(input logic s, input logic r, input logic f, input logic v, input int c);
    start = s; ref_edge = r; fb_edge = f; tdc_valid = v; tdc_code = TW'(c);
    @(negedge clk);
    start = 0; ref_edge = 0; fb_edge = 0; tdc_valid = 0;
  endtask

  function automatic longint model_init(longint w, longint mn, longint ms, longint tg);
    longint n, q;
    n = (tg > mn) ? w * (tg - mn) : 0;
    q = n / (ms - mn);
    return (q > WMAX) ? WMAX : q;
  endfunction

  task automatic trial(input int npre, input int nfb, input int mn, input int ms,
                       input int tg, input bit extra_min, input bit gaps);
    longint w = 0;
    tgt_period = TW'(tg);
    cyc(1, 0, 0, 0, 0);
    chk("R1", "word after start", ctrl_word, 0);
    chk("R1", "done after start", done, 0);
    for (int i = 0; i < npre; i++) cyc(0, 0, 1, 0, 0);
    chk("R2", "word before first ref", ctrl_word, 0);
    cyc(0, 1, 1, 0, 0);
    chk("R2", "word at first ref", ctrl_word, 0);
    cyc(0, 0, 0, 1, mn);
    if (extra_min) cyc(0, 0, 0, 1, mn + 7);
    for (int i = 0; i < nfb; i++) begin
      cyc(0, 0, 1, 0, 0);
      w = (w + STEP > WMAX) ? WMAX : w + STEP;
      if (gaps && (i % 3 == 1)) cyc(0, 0, 0, 0, 0);
      if (i == nfb / 2) begin
        cyc(1, 0, 0, 0, 0);
        chk("R1", "start ignored in ramp", ctrl_word, w);
      end
    end
    chk("R3", "ramped word", ctrl_word, w);
    cyc(0, 1, 1, 0, 0);
    chk("R4", "word at second ref", ctrl_word, w);
    cyc(0, 0, 1, 0, 0);
    chk("R4", "word held after ramp", ctrl_word, w);
    cyc(0, 0, 0, 1, ms);
    chk("R5", "meas_period", meas_period, ms);
    if (ms <= mn) begin
      chk("R7", "err", err, 1);
      chk("R7", "done", done, 1);
      chk("R7", "init_word", init_word, 0);
    end else begin
      for (int i = 0; i < NB; i++) cyc(0, 0, 0, 0, 0);
      chk("R8", "done early", done, 0);
      cyc(0, 0, 0, 0, 0);
      chk("R8", "done on time", done, 1);
      chk("R6", "init_word", init_word, model_init(w, mn, ms, tg));
      chk("R7", "err on valid path", err, 0);
    end
    cyc(0, 0, 1, 0, 0);
    chk("R4", "word in done", ctrl_word, w);
    chk("R8", "done holds", done, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_err++;
    $display("FAIL R8 watchdog expired: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd4242);
    repeat (3) @(negedge clk);
    chk("R1", "reset ctrl_word", ctrl_word, 0);
    chk("R1", "reset done", done, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "idle init_word", init_word, 0);
    chk("R1", "idle err", err, 0);
    chk("R1", "idle meas_period", meas_period, 0);
    // directed corners
    trial(3, 10, 200, 300, 260, 1, 0);   // extra min strobe ignored
    trial(0, 0, 150, 300, 250, 0, 0);    // zero ramp word
    trial(2, 20, 200, 200, 300, 0, 1);   // equal codes -> error
    trial(1, 20, 300, 100, 300, 0, 0);   // reversed codes -> error
    trial(0, 20, 200, 400, 100, 0, 0);   // target below minimum
    trial(0, 830, 100, 101, 1000, 0, 0); // word and quotient saturate
    trial(4, 40, 100, 101, 900, 1, 1);   // quotient saturates only
    // random
    for (int t = 0; t < 40; t++) begin
      int mn, ms, tg;
      mn = 100 + int'($urandom % 200);
      ms = (t % 6 == 5) ? mn - int'($urandom % 50) : mn + 1 + int'($urandom % 600);
      if (ms > 1023) ms = 1023;
      tg = int'($urandom % 1024);
      trial(int'($urandom % 5), int'($urandom % 60), mn, ms, tg,
            1'($urandom % 2), 1'($urandom % 2));
    end
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule